// File: doc/BRIEF.md
# Reloading Watchdog Pulse Timer

This block is a free-running supervision timer. A wide down-counter steps once per divided clock period (by default one step every two input clock cycles) and, when it runs out, refills itself from a programmable reload register and lowers its output for a fixed number of step periods. Software that is healthy keeps the output from ever firing by servicing the timer with a kick strobe, which refills the counter before it runs out. The output is meant to be routed to a system reset or to a non-maskable interrupt input; that consuming logic is outside the block.

Software programs the block through a single-cycle reload write (value plus write strobe), an enable level and the kick strobe. While the enable is low the count is frozen, the output rests high, and a reload write also updates the live count, so a fresh timeout can be set up before the timer is started. Once running, the counter keeps cycling: each expiry refills it and starts a new pulse, and an expiry that arrives while a pulse is still active extends the pulse to its full width again.

Top module: `wdt_pulse_timer`

## Requirements
- R1: After synchronous reset the output `wdt_n` is high, the count and the reload register both hold `RESET_RELOAD` (default all ones), and the divider phase is zero.
- R2: While `en` is high the count steps once every `DIV` input clock cycles; the divider phase is cleared whenever `en` is low, so the first step after enabling falls on the `DIV`-th rising edge with `en` high.
- R3: A step taken when the count is 1 (or 0) is an expiry: instead of reaching zero, the counter refills from the reload register. With a count of N ≥ 1 loaded and the block then enabled, `wdt_n` falls on the `DIV*N`-th rising edge with `en` high.
- R4: Expiries repeat without software action, the falling edges of `wdt_n` being `DIV*N` clock cycles apart for a reload value N.
- R5: The output is active-low: each expiry drives `wdt_n` low for exactly `PULSE_TICKS*DIV` clock cycles (default 8), after which it returns high.
- R6: An expiry during an active pulse restarts the pulse at its full width, so with `DIV*N` ≤ `PULSE_TICKS*DIV` the output stays low continuously.
- R7: A kick with `en` high refills the count from the reload register and wins over a step or expiry in the same cycle; periodic kicks that come more often than the timeout keep `wdt_n` high. A kick with `en` low has no effect.
- R8: With `en` low the count holds its value (apart from R9 writes), any pulse is cancelled, and `wdt_n` is high from the next rising edge.
- R9: A reload write always updates the reload register; with `en` low it also loads the written value into the count, while with `en` high the running count is left alone and the new value takes effect at the next refill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock (oscillator rate) |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low freezes the count and silences the output |
| reload_we | input | 1 | Write strobe for the reload register |
| reload_data | input | CNT_W | Value written to the reload register |
| kick | input | 1 | Service strobe; refills the count while enabled |
| wdt_n | output | 1 | Registered active-low timeout pulse |

## Verification
The in-RTL properties watch the per-cycle contracts: the divider never steps on two adjacent cycles, a frozen count stays put, kicks and expiries refill from the reload register, a normal step subtracts exactly one, every expiry pulls the output low on the next edge, every falling output edge is preceded by an expiry, and a disabled block drives the output high. What the properties cannot show is the end-to-end timing, which the bench measures: the delay from enabling to the first pulse for several reload values, the exact pulse width, the repeat period, the merged pulse when expiries come faster than the pulse, the resumption of a frozen count, and the deferred effect of a reload written while running.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  // What the down-counter does on a given clock cycle.
  typedef enum logic [2:0] {
    ACT_HOLD,
    ACT_WRLOAD,
    ACT_KICK,
    ACT_STEP,
    ACT_EXPIRE
  } cnt_act_e;

  localparam int unsigned DEF_CNT_W       = 32;
  localparam int unsigned DEF_DIV         = 2;
  localparam int unsigned DEF_PULSE_TICKS = 4;

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int unsigned DIV = wdt_pkg::DEF_DIV
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);

  generate
    if (DIV <= 1) begin : g_nodiv
      assign tick = run;
    end else begin : g_div
      localparam int unsigned PRE_W = $clog2(DIV);
      localparam logic [PRE_W-1:0] LAST = PRE_W'(DIV - 1);

      logic [PRE_W-1:0] phase_q;

      always_ff @(posedge clk) begin
        if (rst || !run) begin
          phase_q <= '0;
        end else if (phase_q == LAST) begin
          phase_q <= '0;
        end else begin
          phase_q <= phase_q + 1'b1;
        end
      end

      assign tick = run && (phase_q == LAST);

      // R2: with a divide ratio of two or more, steps never fall on adjacent cycles
      assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

      // R2: a disabled divider restarts its phase
      assert_phase_clear_R2: assert property (@(posedge clk) disable iff (rst)
        !run |=> (phase_q == '0));
    end
  endgenerate

endmodule

// File: rtl/wdt_down_counter.sv
module wdt_down_counter
  import wdt_pkg::*;
#(
  parameter int unsigned         CNT_W        = DEF_CNT_W,
  parameter logic [CNT_W-1:0]    RESET_RELOAD = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             tick,
  input  logic             kick,
  input  logic             reload_we,
  input  logic [CNT_W-1:0] reload_data,
  output logic             expire
);

  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] count_q;
  cnt_act_e         act;

  // Action decode: kick beats step/expiry, disabled only accepts writes.
  always_comb begin
    act = ACT_HOLD;
    if (!en) begin
      if (reload_we) act = ACT_WRLOAD;
    end else if (kick) begin
      act = ACT_KICK;
    end else if (tick) begin
      act = (count_q <= CNT_W'(1)) ? ACT_EXPIRE : ACT_STEP;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= RESET_RELOAD;
    end else if (reload_we) begin
      reload_q <= reload_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= RESET_RELOAD;
    end else begin
      unique case (act)
        ACT_WRLOAD: count_q <= reload_data;
        ACT_KICK:   count_q <= reload_q;
        ACT_EXPIRE: count_q <= reload_q;
        ACT_STEP:   count_q <= count_q - 1'b1;
        default:    count_q <= count_q;
      endcase
    end
  end

  assign expire = (act == ACT_EXPIRE);

  // R8: frozen count while disabled and not written
  assert_frozen_count_R8: assert property (@(posedge clk) disable iff (rst)
    (!en && !reload_we) |=> $stable(count_q));

  // R7: an enabled kick refills from the reload register
  assert_kick_refill_R7: assert property (@(posedge clk) disable iff (rst)
    (en && kick) |=> (count_q == $past(reload_q)));

  // R3: expiry refills instead of reaching zero
  assert_expire_refill_R3: assert property (@(posedge clk) disable iff (rst)
    expire |=> (count_q == $past(reload_q)));

  // R9: a write while disabled lands in the live count
  assert_write_loads_R9: assert property (@(posedge clk) disable iff (rst)
    (!en && reload_we) |=> (count_q == $past(reload_data)));

  // R2: an ordinary step removes exactly one
  assert_step_one_R2: assert property (@(posedge clk) disable iff (rst)
    (en && !kick && tick && (count_q > CNT_W'(1))) |=> (count_q == $past(count_q) - 1'b1));

endmodule

// File: rtl/wdt_pulse_gen.sv
module wdt_pulse_gen #(
  parameter int unsigned PULSE_TICKS = wdt_pkg::DEF_PULSE_TICKS
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic tick,
  input  logic expire,
  output logic pulse_n
);

  localparam int unsigned PW = $clog2(PULSE_TICKS + 1);
  localparam logic [PW-1:0] FULL = PW'(PULSE_TICKS);

  logic [PW-1:0] left_q;
  logic [PW-1:0] left_nxt;

  always_comb begin
    if (!en) begin
      left_nxt = '0;
    end else if (expire) begin
      left_nxt = FULL;
    end else if (tick && (left_q != '0)) begin
      left_nxt = left_q - 1'b1;
    end else begin
      left_nxt = left_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q  <= '0;
      pulse_n <= 1'b1;
    end else begin
      left_q  <= left_nxt;
      pulse_n <= (left_nxt == '0);
    end
  end

  // R5/R6: every expiry (also during a pulse) drives the output low next cycle
  assert_expire_drives_low_R6: assert property (@(posedge clk) disable iff (rst)
    expire |=> (!pulse_n && (left_q == FULL)));

  // R8: disabled means idle-high on the next edge
  assert_idle_when_off_R8: assert property (@(posedge clk) disable iff (rst)
    !en |=> pulse_n);

  // R5: pulse countdown moves only on steps
  assert_width_step_R5: assert property (@(posedge clk) disable iff (rst)
    (en && !expire && !tick) |=> $stable(left_q));

endmodule

// File: rtl/wdt_pulse_timer.sv
module wdt_pulse_timer
  import wdt_pkg::*;
#(
  parameter int unsigned      CNT_W        = DEF_CNT_W,
  parameter int unsigned      DIV          = DEF_DIV,
  parameter int unsigned      PULSE_TICKS  = DEF_PULSE_TICKS,
  parameter logic [CNT_W-1:0] RESET_RELOAD = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             reload_we,
  input  logic [CNT_W-1:0] reload_data,
  input  logic             kick,
  output logic             wdt_n
);

  logic tick;
  logic expire;

  wdt_prescaler #(.DIV(DIV)) i_prescaler (
    .clk  (clk),
    .rst  (rst),
    .run  (en),
    .tick (tick)
  );

  wdt_down_counter #(
    .CNT_W        (CNT_W),
    .RESET_RELOAD (RESET_RELOAD)
  ) i_counter (
    .clk         (clk),
    .rst         (rst),
    .en          (en),
    .tick        (tick),
    .kick        (kick),
    .reload_we   (reload_we),
    .reload_data (reload_data),
    .expire      (expire)
  );

  wdt_pulse_gen #(.PULSE_TICKS(PULSE_TICKS)) i_pulse (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .tick    (tick),
    .expire  (expire),
    .pulse_n (wdt_n)
  );

  // R5: a falling output edge always follows an expiry
  assert_fall_needs_expire_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(wdt_n) |-> $past(expire));

  // R7: a kick never lets the output fall on the next edge unless already pulsing
  assert_kick_no_fire_R7: assert property (@(posedge clk) disable iff (rst)
    (en && kick && wdt_n) |=> wdt_n);

endmodule

// File: tb/test_wdt_pulse_timer.sv
`timescale 1ns/1ps
module test_wdt_pulse_timer;

  localparam int DIV   = 2;
  localparam int PULSE = 4;
  localparam int NV    = 4;
  // reload value, expected edges to first fall, width, repeat period
  localparam int VEC_N[NV]      = '{5, 7, 9, 12};
  localparam int VEC_FIRST[NV]  = '{10, 14, 18, 24};
  localparam int VEC_WIDTH[NV]  = '{8, 8, 8, 8};
  localparam int VEC_PERIOD[NV] = '{10, 14, 18, 24};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic        reload_we = 1'b0;
  logic [31:0] reload_data = '0;
  logic        kick = 1'b0;
  logic        wdt_n;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  wdt_pulse_timer #(.CNT_W(32), .DIV(DIV), .PULSE_TICKS(PULSE)) i_wdt_pulse_timer (
    .clk(clk), .rst(rst), .en(en), .reload_we(reload_we),
    .reload_data(reload_data), .kick(kick), .wdt_n(wdt_n)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic write_reload(input int val);
    @(negedge clk);
    reload_we = 1'b1;
    reload_data = val;
    @(negedge clk);
    reload_we = 1'b0;
  endtask

  // edges until wdt_n samples low (limit returns -1)
  task automatic edges_to_low(output int n);
    n = 0;
    do begin
      step();
      n++;
    end while (wdt_n && n < 2000);
    if (wdt_n) n = -1;
  endtask

  task automatic edges_to_high(output int n);
    n = 0;
    do begin
      step();
      n++;
    end while (!wdt_n && n < 2000);
    if (!wdt_n) n = -1;
  endtask

  initial begin
    int n, w, p, lows;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1 idle-high after reset", wdt_n, 1);

    // R1: reset reload is all ones, so nothing fires soon
    @(negedge clk); en = 1'b1;
    lows = 0;
    for (int i = 0; i < 50; i++) begin step(); if (!wdt_n) lows++; end
    check("R1 no early pulse", lows, 0);
    @(negedge clk); en = 1'b0;

    // Vector table: R2/R3 first fall, R5 width, R4 repeat period
    for (int v = 0; v < NV; v++) begin
      write_reload(VEC_N[v]);
      en = 1'b1;
      edges_to_low(n);
      check("R3 first fall", n, VEC_FIRST[v]);
      edges_to_high(w);
      check("R5 pulse width", w, VEC_WIDTH[v]);
      edges_to_low(p);
      check("R4 repeat period", w + p, VEC_PERIOD[v]);
      @(negedge clk); en = 1'b0;
      #2;
      step();
      check("R8 high when disabled", wdt_n, 1);
    end

    // R6: expiry every 6 cycles with an 8-cycle pulse merges into steady low
    write_reload(3);
    en = 1'b1;
    edges_to_low(n);
    check("R6 first fall", n, 6);
    lows = 0;
    for (int i = 0; i < 30; i++) begin step(); if (!wdt_n) lows++; end
    check("R6 stays low", lows, 30);
    @(negedge clk); en = 1'b0;
    step();
    check("R8 pulse cancelled", wdt_n, 1);

    // R7: periodic kicks keep the output high
    write_reload(5);
    en = 1'b1;
    lows = 0;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      kick = (i % 4 == 0);
      step();
      if (!wdt_n) lows++;
    end
    @(negedge clk); kick = 1'b0;
    check("R7 kicks prevent pulse", lows, 0);
    en = 1'b0;

    // R8 hold + R7 kick ignored while disabled
    write_reload(10);
    en = 1'b1;
    repeat (6) step();        // three steps: count 10 -> 7
    @(negedge clk); en = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); kick = (i % 2 == 0);
    end
    @(negedge clk); kick = 1'b0;
    check("R8 high while frozen", wdt_n, 1);
    en = 1'b1;
    edges_to_low(n);
    check("R8 frozen count resumes", n, 14);
    @(negedge clk); en = 1'b0;

    // R9: write while running only affects the next refill
    write_reload(10);
    en = 1'b1;
    repeat (2) step();
    @(negedge clk);
    reload_we = 1'b1; reload_data = 6;
    @(negedge clk);
    reload_we = 1'b0;
    // 3 rising edges so far with en high (2 + 1 during the write)
    edges_to_low(n);
    check("R9 running count untouched", n + 3, 20);
    edges_to_high(w);
    edges_to_low(p);
    check("R9 new reload at refill", w + p, 12);
    @(negedge clk); en = 1'b0;

    // R1: reset restores idle state mid-pulse
    write_reload(5);
    en = 1'b1;
    edges_to_low(n);
    @(negedge clk); rst = 1'b1; en = 1'b0;
    step();
    @(negedge clk); rst = 1'b0;
    check("R1 reset clears pulse", wdt_n, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1500000;
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule